// File: doc/BRIEF.md
# Hash-Versus-Target Checker with Lowest-Nonce Capture

This block sits behind a hash engine during a nonce scan. Each cycle it may take one pair made of a 32-bit nonce and the 256-bit hash computed for it. It decides whether that hash, read as an unsigned 256-bit number, is less than or equal to a stored 256-bit target. Over a scan batch it keeps the smallest nonce whose hash met the target. The block cannot see the order in which nonces arrive, so the kept value does not depend on that order.

Software loads the target one 32-bit word at a time. It pulses a batch-clear at the start of a scan. It reads the kept nonce and a found flag when the scan ends. The kept value reads all ones while nothing has been found. The input stream uses valid/ready. The block deasserts ready only in a cycle where batch-clear is high. In that cycle a presented pair is not accepted, and the producer must hold it and present it again. In every other cycle a pair is accepted in the cycle it is presented, so the throughput is one pair per clock.

Top module: `hash_target_checker`

## Requirements
- R1: After reset, result_nonce reads 32'hFFFFFFFF, found reads 0 and in_ready reads 1.
- R2: A target load with tgt_we high writes tgt_word into target word tgt_idx. Word k of the hash is in_hash[32k+31:32k]. Word 7 is the most significant word of the 256-bit value and word 0 the least significant.
- R3: The highest-index word in which the hash and target differ decides the result. There the hash passes if its word is smaller and fails if its word is larger, whatever the lower words hold.
- R4: A hash equal to the target in all eight words passes.
- R5: An accepted passing nonce replaces result_nonce only if it is strictly smaller than the stored value. A failing nonce never changes it, and neither does a passing 32'hFFFFFFFF. result_nonce never increases except on a batch clear.
- R6: In a cycle with batch_clr high, in_ready is 0 and any presented pair is dropped. From the next cycle result_nonce reads 32'hFFFFFFFF and found reads 0.
- R7: found equals 1 exactly when result_nonce differs from 32'hFFFFFFFF.
- R8: A pair accepted at a rising edge updates result_nonce and found at that same edge, so they are visible one cycle after the valid cycle. Back-to-back pairs are accepted every cycle.
- R9: A target write never changes result_nonce. A pair accepted in the same cycle as a target write is compared against the target as it stood before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_we | input | 1 | Target word write strobe |
| tgt_idx | input | 3 | Index of the target word to write (7 = most significant) |
| tgt_word | input | 32 | Target word data |
| batch_clr | input | 1 | Single-cycle pulse that starts a batch and presets the result |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high together with in_valid |
| in_nonce | input | 32 | Nonce of the input pair |
| in_hash | input | 256 | Hash of the input pair, word k at bits 32k+31:32k |
| result_nonce | output | 32 | Smallest passing nonce of the batch, all ones when none |
| found | output | 1 | High when result_nonce holds a found nonce |

## Verification
The only state visible outside the block is the result register. A wrong word ordering, a wrong tie rule or a target word written to the wrong slot shows as a passing pair that leaves result_nonce unchanged, or a failing pair that replaces it. Either error is visible in the cycle right after that pair was accepted. A broken minimum rule shows after the first larger passing nonce that follows a smaller one. A clear that fails to win over a same-cycle input, or a target write that touches the result, shows on result_nonce one cycle later. The bench therefore checks the result after every stimulus cycle and not only at the end of a batch.

// File: rtl/hcmp_pkg.sv
package hcmp_pkg;

  // Ordering of one hash word against the matching target word.
  typedef enum logic [1:0] {
    ORD_EQ = 2'b00,
    ORD_LT = 2'b01,
    ORD_GT = 2'b10
  } word_ord_e;

endpackage

// File: rtl/hcmp_target_store.sv
module hcmp_target_store #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NWORDS = 8,
  localparam int unsigned IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDX_W-1:0]           idx,
  input  logic [WORD_W-1:0]          wdata,
  output logic [NWORDS*WORD_W-1:0]   target
);

  // One register per word; each decodes its own index.
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (we && (idx == IDX_W'(k))) begin
        word_q <= wdata;
      end
    end

    assign target[k*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/hcmp_word_cmp.sv
module hcmp_word_cmp #(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0]  hash_w,
  input  logic [WORD_W-1:0]  tgt_w,
  output hcmp_pkg::word_ord_e ord
);

  always_comb begin
    if (hash_w < tgt_w) begin
      ord = hcmp_pkg::ORD_LT;
    end else if (hash_w > tgt_w) begin
      ord = hcmp_pkg::ORD_GT;
    end else begin
      ord = hcmp_pkg::ORD_EQ;
    end
  end

endmodule

// File: rtl/hcmp_pass_resolve.sv
module hcmp_pass_resolve #(
  parameter int unsigned NWORDS = 8
) (
  input  hcmp_pkg::word_ord_e ord [NWORDS],
  output logic                pass
);

  // Walk upward so a higher differing word overrides a lower one.
  // All-equal leaves the initial pass value standing.
  always_comb begin
    pass = 1'b1;
    for (int i = 0; i < NWORDS; i++) begin
      if (ord[i] == hcmp_pkg::ORD_GT) begin
        pass = 1'b0;
      end else if (ord[i] == hcmp_pkg::ORD_LT) begin
        pass = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hcmp_min_keep.sv
module hcmp_min_keep #(
  parameter int unsigned NONCE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               take,
  input  logic [NONCE_W-1:0] nonce,
  output logic [NONCE_W-1:0] result
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '1;
    end else if (clr) begin
      result <= '1;
    end else if (take && (nonce < result)) begin
      result <= nonce;
    end
  end

endmodule

// File: rtl/hash_target_checker.sv
module hash_target_checker #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned NWORDS  = 8,
  parameter int unsigned NONCE_W = 32,
  localparam int unsigned IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int unsigned HASH_W = NWORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tgt_we,
  input  logic [IDX_W-1:0]   tgt_idx,
  input  logic [WORD_W-1:0]  tgt_word,
  input  logic               batch_clr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [NONCE_W-1:0] in_nonce,
  input  logic [HASH_W-1:0]  in_hash,
  output logic [NONCE_W-1:0] result_nonce,
  output logic               found
);

  logic [HASH_W-1:0]   target;
  hcmp_pkg::word_ord_e ord [NWORDS];
  logic                hash_pass;
  logic                accept;

  hcmp_target_store #(
    .WORD_W (WORD_W),
    .NWORDS (NWORDS)
  ) u_target (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tgt_we),
    .idx    (tgt_idx),
    .wdata  (tgt_word),
    .target (target)
  );

  for (genvar k = 0; k < NWORDS; k++) begin : g_cmp
    hcmp_word_cmp #(
      .WORD_W (WORD_W)
    ) u_cmp (
      .hash_w (in_hash[k*WORD_W +: WORD_W]),
      .tgt_w  (target[k*WORD_W +: WORD_W]),
      .ord    (ord[k])
    );
  end

  hcmp_pass_resolve #(
    .NWORDS (NWORDS)
  ) u_resolve (
    .ord  (ord),
    .pass (hash_pass)
  );

  // Clear owns the cycle: the pair is refused, not silently lost.
  assign in_ready = ~batch_clr;
  assign accept   = in_valid & in_ready;

  hcmp_min_keep #(
    .NONCE_W (NONCE_W)
  ) u_min (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (batch_clr),
    .take   (accept & hash_pass),
    .nonce  (in_nonce),
    .result (result_nonce)
  );

  assign found = (result_nonce != {NONCE_W{1'b1}});

endmodule

// File: rtl/hcmp_checker.sv
module hcmp_checker #(
  parameter int unsigned NONCE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               batch_clr,
  input logic               in_valid,
  input logic [NONCE_W-1:0] in_nonce,
  input logic [NONCE_W-1:0] result_nonce,
  input logic               found
);

  AST_CLEAR_PRESETS: assert property (@(posedge clk) disable iff (!rst_n)
    batch_clr |=> (result_nonce == {NONCE_W{1'b1}})); // R6

  AST_CLEAR_DROPS_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
    batch_clr |=> !found); // R7

  AST_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    !batch_clr |=> (result_nonce <= $past(result_nonce))); // R5

  AST_CHANGE_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !batch_clr |=> ((result_nonce == $past(result_nonce)) ||
                    ($past(in_valid) && (result_nonce == $past(in_nonce))))); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!batch_clr && !in_valid) |=> $stable(result_nonce)); // R9

endmodule

bind hash_target_checker hcmp_checker #(
  .NONCE_W (NONCE_W)
) u_hcmp_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .batch_clr    (batch_clr),
  .in_valid     (in_valid),
  .in_nonce     (in_nonce),
  .result_nonce (result_nonce),
  .found        (found)
);

// File: tb/hash_target_checker_test.sv
module hash_target_checker_test;

  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tgt_we = 1'b0;
  logic [2:0]   tgt_idx = '0;
  logic [31:0]  tgt_word = '0;
  logic         batch_clr = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_nonce = '0;
  logic [255:0] in_hash = '0;
  logic [31:0]  result_nonce;
  logic         found;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hash_target_checker uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .tgt_we       (tgt_we),
    .tgt_idx      (tgt_idx),
    .tgt_word     (tgt_word),
    .batch_clr    (batch_clr),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_nonce     (in_nonce),
    .in_hash      (in_hash),
    .result_nonce (result_nonce),
    .found        (found)
  );

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input logic [31:0] w7, input logic [31:0] w6,
                                      input logic [31:0] rest);
    return {w7, w6, {6{rest}}};
  endfunction

  // Load all eight words, word 0 first, one per cycle.
  task automatic load_target(input logic [255:0] t);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      tgt_we   = 1'b1;
      tgt_idx  = 3'(k);
      tgt_word = t[k*32 +: 32];
    end
    @(negedge clk);
    tgt_we = 1'b0;
  endtask

  task automatic clear_batch();
    @(negedge clk);
    batch_clr = 1'b1;
    @(negedge clk);
    batch_clr = 1'b0;
  endtask

  // Present one pair for one cycle, then check at the following negedge.
  task automatic push_check(input logic [31:0] n, input logic [255:0] h,
                            input logic [31:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_nonce = n;
    in_hash  = h;
    @(negedge clk);
    in_valid = 1'b0;
    check32(result_nonce, exp, tag);
    check32({31'd0, found}, {31'd0, exp != NONE}, {tag, " found R7"});
  endtask

  task automatic t_reset();
    check32(result_nonce, NONE, "R1 result after reset");
    check32({31'd0, found}, 32'd0, "R1 found after reset");
    check32({31'd0, in_ready}, 32'd1, "R1 ready after reset");
  endtask

  task automatic t_load_and_pass();
    load_target(mk(32'h0000_00FF, NONE, NONE));
    clear_batch();
    push_check(32'd100, mk(32'h0000_00FE, NONE, NONE), 32'd100, "R2 target word7 loaded, pass");
  endtask

  task automatic t_order();
    logic [255:0] t = mk(32'h0000_0100, 32'h8000_0000, 32'h0);
    load_target(t);
    clear_batch();
    push_check(32'd9, mk(32'h0000_0101, 32'h0, 32'h0), NONE, "R3 word7 greater fails");
    push_check(32'd9, mk(32'h0000_0100, 32'h8000_0001, 32'h0), NONE, "R3 word6 greater fails");
    push_check(32'd9, mk(32'h0000_0100, 32'h7FFF_FFFF, NONE), 32'd9, "R3 word6 smaller passes");
    clear_batch();
    push_check(32'd8, mk(32'h0000_00FF, NONE, NONE), 32'd8, "R3 word7 smaller passes");
    clear_batch();
    push_check(32'd4, {t[255:32], 32'h1}, NONE, "R3 word0 greater fails");
    push_check(32'd4, t, 32'd4, "R4 equal passes");
  endtask

  task automatic t_minimum();
    logic [255:0] ok  = mk(32'h0, 32'h0, 32'h0);
    logic [255:0] bad = mk(NONE, NONE, NONE);
    load_target(mk(32'h0000_1000, 32'h0, 32'h0));
    clear_batch();
    push_check(NONE, ok, NONE, "R5 passing all-ones nonce no change");
    push_check(32'd50, ok, 32'd50, "R5 first pass");
    push_check(32'd80, ok, 32'd50, "R5 larger pass ignored");
    push_check(32'd5, bad, 32'd50, "R5 failing smaller ignored");
    push_check(32'd50, ok, 32'd50, "R5 equal pass kept");
    push_check(32'd20, ok, 32'd20, "R5 smaller pass taken");
    // Back-to-back stream, one pair per cycle.
    clear_batch();
    @(negedge clk);
    in_valid = 1'b1; in_nonce = 32'd30; in_hash = ok;
    @(negedge clk);
    check32(result_nonce, 32'd30, "R8 one cycle latency");
    in_nonce = 32'd10;
    @(negedge clk);
    check32(result_nonce, 32'd10, "R8 second pair next cycle");
    in_nonce = 32'd40;
    @(negedge clk);
    in_valid = 1'b0;
    check32(result_nonce, 32'd10, "R8 third pair larger kept min");
  endtask

  task automatic t_clear_priority();
    @(negedge clk);
    batch_clr = 1'b1;
    in_valid  = 1'b1;
    in_nonce  = 32'd3;
    in_hash   = '0;
    #1;
    check32({31'd0, in_ready}, 32'd0, "R6 ready low during clear");
    @(negedge clk);
    batch_clr = 1'b0;
    in_valid  = 1'b0;
    check32(result_nonce, NONE, "R6 clear wins over same-cycle pair");
    check32({31'd0, found}, 32'd0, "R6 found low after clear");
    @(negedge clk);
    check32(result_nonce, NONE, "R6 dropped pair not applied later");
  endtask

  task automatic t_target_write();
    load_target(mk(32'h0000_0100, 32'h0, 32'h0));
    clear_batch();
    push_check(32'd12, mk(32'h0000_0050, 32'h0, 32'h0), 32'd12, "R9 setup pass");
    load_target(mk(32'h0, 32'h0, 32'h0));
    check32(result_nonce, 32'd12, "R9 target write keeps result");
    load_target(mk(32'h0000_0100, 32'h0, 32'h0));
    // Same-cycle write lowers word7; the pair sees the old target.
    @(negedge clk);
    tgt_we = 1'b1; tgt_idx = 3'd7; tgt_word = 32'h0;
    in_valid = 1'b1; in_nonce = 32'd7; in_hash = mk(32'h0000_0050, 32'h0, 32'h0);
    @(negedge clk);
    tgt_we = 1'b0; in_valid = 1'b0;
    check32(result_nonce, 32'd7, "R9 same-cycle pair uses old target");
    push_check(32'd6, mk(32'h0000_0050, 32'h0, 32'h0), 32'd7, "R9 new target applied after write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_and_pass();
    t_order();
    t_minimum();
    t_clear_priority();
    t_target_write();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule